// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Engine

This block moves outgoing frames from memory to a byte stream. Software places descriptors in a ring in memory, four 32-bit words each, sixteen bytes apart from a programmable base address. To hand a descriptor to the engine, software clears its done flag, fills in the buffer pointer and length, and then moves a CPU index register forward by one, modulo the ring size. The engine keeps its own DMA index. Whenever transmission is enabled and the two indices differ, it reads the descriptor at its DMA index and fetches the frame buffer word by word. It sends the frame as bytes marked with start and end flags, optionally writes the control word back with the done flag set, and then moves its index forward.

The engine has three interfaces. A simple request/grant memory port carries descriptor reads, buffer reads and done write-backs. A small register interface gives access to the ring base, the ring size, the CPU index, the DMA index, an index-clear strobe and a control register. The output is a byte stream with a ready input for backpressure. Only segment 0 of a descriptor is used. The second buffer pointer and the info word are never read.

Top module: `txr_dma_top`

## Requirements
- R1: After reset, the register values are: ring base 0, ring size 24, CPU index 0, DMA index 0, control 0. The outputs `st_valid` and `mem_req` are both 0.
- R2: The descriptor at DMA index i starts at byte address base + 16*i. The engine reads the buffer pointer at offset 0 and the control word at offset 4. In the control word, the segment-0 length is bits [29:16] and the done flag is bit 31. The buffer pointer must be word aligned.
- R3: A frame of length L produces exactly L bytes, in address order, with byte lane 0 of each memory word first. `st_sof` is 1 on the first byte only and `st_eof` is 1 on the last byte only. Neither flag is ever 1 unless `st_valid` is also 1.
- R4: While `st_valid` is 1 and `st_ready` is 0, `st_valid`, `st_data`, `st_sof` and `st_eof` hold their values into the next cycle.
- R5: Write-back depends on the control register. When write-back enable (bit 1) is set, the engine rewrites the control word with bit 31 set and every other bit unchanged. When it is clear, the engine writes nothing to memory.
- R6: The engine processes descriptors while its DMA index differs from the CPU index. The DMA index wraps from ring size minus 1 to 0.
- R7: A write to register 4 with bit 0 set forces the DMA index to 0. This takes priority over an advance that completes in the same cycle.
- R8: Clearing the enable bit (control bit 0) stops the engine from taking any new descriptor, but a frame already in flight still completes. The busy flag (control bit 2, read only) is 1 from the moment a descriptor is taken until it is finished.
- R9: A descriptor whose segment-0 length is zero produces no output bytes, and the engine still marks it done.
- R10: Once `mem_req` is raised, it stays at 1 with `mem_addr` and `mem_we` unchanged until a cycle in which `mem_gnt` is 1. Read data is taken in a later cycle, when `mem_rvalid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 base, 1 size, 2 CPU index, 3 DMA index (read only), 4 index clear, 5 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | The request is accepted in this cycle |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | 32 | Read data |
| st_valid | output | 1 | Output byte valid |
| st_data | output | 8 | Output byte |
| st_sof | output | 1 | First byte of a frame |
| st_eof | output | 1 | Last byte of a frame |
| st_ready | input | 1 | The downstream side accepts the byte |

## Verification
Two events can fall in the same cycle: the done write-back is granted, which advances the DMA index, and software writes the index-clear register. The bench provokes this by holding off the grant for write requests. It waits until the write-back request is pending and transmission has been disabled. Then, at one falling edge, it releases the grant and issues the index-clear write. The collision is judged correct if, afterwards, the DMA index reads 0 rather than the advanced value, and the descriptor in memory still carries its done flag.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int WORD_W     = 32;
    localparam int SEG_LEN_W  = 14;
    localparam int DESC_BYTES = 16;
    localparam int OFS_PTR0   = 0;
    localparam int OFS_CTL    = 4;

    // register select codes
    localparam logic [2:0] RA_BASE = 3'd0;
    localparam logic [2:0] RA_SIZE = 3'd1;
    localparam logic [2:0] RA_CPU  = 3'd2;
    localparam logic [2:0] RA_DMA  = 3'd3;
    localparam logic [2:0] RA_ICLR = 3'd4;
    localparam logic [2:0] RA_CTRL = 3'd5;

    // control register bits
    localparam int CB_EN   = 0;
    localparam int CB_WB   = 1;
    localparam int CB_BUSY = 2;

    // control word of a descriptor, most significant field first
    typedef struct packed {
        logic                 done;
        logic                 last0;
        logic [SEG_LEN_W-1:0] len0;
        logic                 burst;
        logic                 last1;
        logic [SEG_LEN_W-1:0] len1;
    } ctl_word_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_PTR,
        S_WT_PTR,
        S_RD_CTL,
        S_WT_CTL,
        S_RD_BUF,
        S_WT_BUF,
        S_DRAIN,
        S_WB
    } walk_st_e;

    // bytes carried by the next buffer word, given what remains
    function automatic logic [2:0] chunk_bytes(input logic [SEG_LEN_W-1:0] rem);
        return (rem >= SEG_LEN_W'(4)) ? 3'd4 : rem[2:0];
    endfunction

endpackage

// File: rtl/txr_regs.sv
module txr_regs
    import txr_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int DEF_RING = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             adv,
    input  logic             busy,
    output logic [31:0]      ring_base,
    output logic [IDX_W-1:0] ring_size,
    output logic [IDX_W-1:0] cpu_idx,
    output logic [IDX_W-1:0] dma_idx,
    output logic             tx_en,
    output logic             wb_en
);

    localparam int PAD_W = WORD_W - IDX_W;

    logic idx_clr;
    assign idx_clr = cfg_we && (cfg_addr == RA_ICLR) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_base <= '0;
            ring_size <= IDX_W'(DEF_RING);
            cpu_idx   <= '0;
            dma_idx   <= '0;
            tx_en     <= 1'b0;
            wb_en     <= 1'b0;
        end else begin
            if (cfg_we) begin
                case (cfg_addr)
                    RA_BASE: ring_base <= cfg_wdata;
                    RA_SIZE: ring_size <= cfg_wdata[IDX_W-1:0];
                    RA_CPU:  cpu_idx   <= cfg_wdata[IDX_W-1:0];
                    RA_CTRL: begin
                        tx_en <= cfg_wdata[CB_EN];
                        wb_en <= cfg_wdata[CB_WB];
                    end
                    default: ;
                endcase
            end
            // R7: clear beats a same-cycle advance
            if (idx_clr)
                dma_idx <= '0;
            else if (adv)
                dma_idx <= (dma_idx == ring_size - 1'b1) ? '0 : dma_idx + 1'b1;
        end
    end

    always_comb begin
        case (cfg_addr)
            RA_BASE: cfg_rdata = ring_base;
            RA_SIZE: cfg_rdata = {{PAD_W{1'b0}}, ring_size};
            RA_CPU:  cfg_rdata = {{PAD_W{1'b0}}, cpu_idx};
            RA_DMA:  cfg_rdata = {{PAD_W{1'b0}}, dma_idx};
            RA_CTRL: cfg_rdata = {29'd0, busy, wb_en, tx_en};
            default: cfg_rdata = '0;
        endcase
    end

    assert_iclr_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == RA_ICLR && cfg_wdata[0]) |=> (dma_idx == '0));

    assert_adv_moves_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && !idx_clr && ring_size > IDX_W'(1)) |=> (dma_idx != $past(dma_idx)));

endmodule

// File: rtl/txr_serializer.sv
module txr_serializer
    import txr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] word,
    input  logic [2:0]  nbytes,
    input  logic        first,
    input  logic        last,
    input  logic        ready,
    output logic        valid,
    output logic [7:0]  data,
    output logic        sof,
    output logic        eof,
    output logic        empty
);

    logic [31:0] word_q;
    logic [2:0]  cnt_q;
    logic [1:0]  pos_q;
    logic        first_q;
    logic        last_q;

    assign valid = (cnt_q != 3'd0);
    assign empty = !valid;
    assign data  = word_q[{pos_q, 3'b000} +: 8];
    assign sof   = valid && first_q && (pos_q == 2'd0);
    assign eof   = valid && last_q && (cnt_q == 3'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            cnt_q   <= '0;
            pos_q   <= '0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (load) begin
            word_q  <= word;
            cnt_q   <= nbytes;
            pos_q   <= '0;
            first_q <= first;
            last_q  <= last;
        end else if (valid && ready) begin
            cnt_q <= cnt_q - 3'd1;
            pos_q <= pos_q + 2'd1;
        end
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(data) && $stable(sof) && $stable(eof)));

    assert_load_empty_R3: assert property (@(posedge clk) disable iff (rst)
        load |-> empty);

    assert_marks_R3: assert property (@(posedge clk) disable iff (rst)
        (sof || eof) |-> valid);

endmodule

// File: rtl/txr_walker.sv
module txr_walker
    import txr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             wb_en,
    input  logic [31:0]      ring_base,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic [IDX_W-1:0] dma_idx,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_gnt,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    input  logic             ser_empty,
    output logic             ld,
    output logic [31:0]      ld_word,
    output logic [2:0]       ld_n,
    output logic             ld_first,
    output logic             ld_last,
    output logic             adv,
    output logic             busy
);

    localparam int PAD_W = WORD_W - IDX_W;

    walk_st_e             st_q;
    logic [31:0]          daddr_q;
    logic                 wb_q;
    logic [31:0]          ptr_q;
    ctl_word_t            ctl_q;
    logic [SEG_LEN_W-1:0] rem_q;
    logic [31:0]          baddr_q;
    logic [31:0]          desc_addr;
    ctl_word_t            ctl_in;

    assign desc_addr = ring_base + ({{PAD_W{1'b0}}, dma_idx} << 4);
    assign ctl_in    = ctl_word_t'(mem_rdata);
    assign busy      = (st_q != S_IDLE);

    assign ld_word  = mem_rdata;
    assign ld_n     = chunk_bytes(rem_q);
    assign ld_first = (rem_q == ctl_q.len0);
    assign ld_last  = (rem_q <= SEG_LEN_W'(4));

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ld        = 1'b0;
        adv       = 1'b0;
        case (st_q)
            S_RD_PTR: begin
                mem_req  = 1'b1;
                mem_addr = daddr_q + 32'(OFS_PTR0);
            end
            S_RD_CTL: begin
                mem_req  = 1'b1;
                mem_addr = daddr_q + 32'(OFS_CTL);
            end
            S_RD_BUF: begin
                mem_req  = ser_empty;
                mem_addr = baddr_q;
            end
            S_WT_BUF: ld = mem_rvalid;
            S_WB: begin
                mem_req   = wb_q;
                mem_we    = wb_q;
                mem_addr  = daddr_q + 32'(OFS_CTL);
                mem_wdata = {1'b1, ctl_q[30:0]};
                adv       = !wb_q || mem_gnt;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            daddr_q <= '0;
            wb_q    <= 1'b0;
            ptr_q   <= '0;
            ctl_q   <= '0;
            rem_q   <= '0;
            baddr_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (tx_en && dma_idx != cpu_idx) begin
                    daddr_q <= desc_addr;
                    wb_q    <= wb_en;
                    st_q    <= S_RD_PTR;
                end
                S_RD_PTR: if (mem_gnt) st_q <= S_WT_PTR;
                S_WT_PTR: if (mem_rvalid) begin
                    ptr_q <= mem_rdata;
                    st_q  <= S_RD_CTL;
                end
                S_RD_CTL: if (mem_gnt) st_q <= S_WT_CTL;
                S_WT_CTL: if (mem_rvalid) begin
                    ctl_q   <= ctl_in;
                    rem_q   <= ctl_in.len0;
                    baddr_q <= ptr_q;
                    st_q    <= (ctl_in.len0 == '0) ? S_WB : S_RD_BUF;
                end
                S_RD_BUF: if (ser_empty && mem_gnt) st_q <= S_WT_BUF;
                S_WT_BUF: if (mem_rvalid) begin
                    rem_q   <= rem_q - {{(SEG_LEN_W-3){1'b0}}, ld_n};
                    baddr_q <= baddr_q + 32'd4;
                    st_q    <= ld_last ? S_DRAIN : S_RD_BUF;
                end
                S_DRAIN: if (ser_empty) st_q <= S_WB;
                S_WB: if (adv) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_wb_done_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[31]);

    assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE && !tx_en) |=> (st_q == S_IDLE));

    assert_zero_len_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_WT_CTL && mem_rvalid && mem_rdata[29:16] == 14'd0) |=> (st_q == S_WB));

endmodule

// File: rtl/txr_dma_top.sv
module txr_dma_top
    import txr_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int DEF_RING = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        st_valid,
    output logic [7:0]  st_data,
    output logic        st_sof,
    output logic        st_eof,
    input  logic        st_ready
);

    logic [31:0]      ring_base;
    logic [IDX_W-1:0] ring_size;
    logic [IDX_W-1:0] cpu_idx;
    logic [IDX_W-1:0] dma_idx;
    logic             tx_en;
    logic             wb_en;
    logic             adv;
    logic             busy;
    logic             ser_empty;
    logic             ld;
    logic [31:0]      ld_word;
    logic [2:0]       ld_n;
    logic             ld_first;
    logic             ld_last;

    txr_regs #(.IDX_W(IDX_W), .DEF_RING(DEF_RING)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .adv(adv), .busy(busy),
        .ring_base(ring_base), .ring_size(ring_size),
        .cpu_idx(cpu_idx), .dma_idx(dma_idx),
        .tx_en(tx_en), .wb_en(wb_en)
    );

    txr_walker #(.IDX_W(IDX_W)) u_walker (
        .clk(clk), .rst(rst),
        .tx_en(tx_en), .wb_en(wb_en),
        .ring_base(ring_base), .cpu_idx(cpu_idx), .dma_idx(dma_idx),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ser_empty(ser_empty),
        .ld(ld), .ld_word(ld_word), .ld_n(ld_n), .ld_first(ld_first), .ld_last(ld_last),
        .adv(adv), .busy(busy)
    );

    txr_serializer u_ser (
        .clk(clk), .rst(rst),
        .load(ld), .word(ld_word), .nbytes(ld_n), .first(ld_first), .last(ld_last),
        .ready(st_ready),
        .valid(st_valid), .data(st_data), .sof(st_sof), .eof(st_eof),
        .empty(ser_empty)
    );

endmodule

// File: tb/txr_dma_top_bench.sv
`timescale 1ns/1ps
module txr_dma_top_bench;

    localparam logic [31:0] RING = 32'h100;
    localparam int NSLOT = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        st_valid, st_sof, st_eof;
    logic [7:0]  st_data;
    logic        st_ready = 1'b0;

    always #2.5 clk = ~clk;

    txr_dma_top u_txr_dma_top (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .st_valid(st_valid), .st_data(st_data), .st_sof(st_sof), .st_eof(st_eof),
        .st_ready(st_ready)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    // memory model with random grants
    logic [31:0] mem [0:2047];
    logic gnt_rand = 1'b0;
    bit   gnt_full = 0;
    bit   wb_allow = 1;
    bit   rdy_hold = 0;
    bit   rdy_rand = 1;
    assign mem_gnt = (mem_we ? wb_allow : 1'b1) && (gnt_rand || gnt_full);

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && mem_gnt) begin
            if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
            else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[12:2]];
            end
        end
        gnt_rand <= 1'($urandom_range(0, 1));
        st_ready <= rdy_hold ? 1'b0 : (rdy_rand ? 1'($urandom_range(0, 3) != 0) : 1'b1);
    end

    // output capture and protocol monitors
    logic [9:0] cap_q [$];
    bit         pst_stall = 0;
    logic [9:0] pst_val;
    int         bp_err = 0, bp_seen = 0;
    bit         prq = 0;
    logic [31:0] prq_addr;
    int         rq_err = 0, rq_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (pst_stall) begin
                bp_seen++;
                if (!(st_valid && {st_sof, st_eof, st_data} == pst_val)) bp_err++;
            end
            pst_stall = st_valid && !st_ready;
            pst_val   = {st_sof, st_eof, st_data};
            if (st_valid && st_ready) cap_q.push_back({st_sof, st_eof, st_data});
            if (prq) begin
                rq_seen++;
                if (!(mem_req && mem_addr == prq_addr)) rq_err++;
            end
            prq      = mem_req && !mem_gnt;
            prq_addr = mem_addr;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    int          exp_len [NSLOT];
    logic [31:0] exp_ctl [NSLOT];
    int          sw_cpu = 0;

    function automatic logic [31:0] slot_ptr(input int slot);
        return 32'h400 + 32'(slot) * 32'd64;
    endfunction

    function automatic int desc_word(input int slot);
        return (int'(RING) + slot * 16) >> 2;
    endfunction

    function automatic logic [7:0] exp_byte(input int slot, input int k);
        logic [31:0] a;
        logic [31:0] w;
        a = slot_ptr(slot) + 32'(k);
        w = mem[a[12:2]];
        return w[8 * int'(a[1:0]) +: 8];
    endfunction

    task automatic fill_desc(input int slot, input int len);
        logic [31:0] ctl;
        int pw;
        ctl = {1'b0, 1'b1, 14'(len), 2'($urandom_range(0, 3)), 14'($urandom_range(0, 16383))};
        mem[desc_word(slot)]     <= slot_ptr(slot);
        mem[desc_word(slot) + 1] <= ctl;
        mem[desc_word(slot) + 2] <= $urandom;
        mem[desc_word(slot) + 3] <= $urandom;
        pw = int'(slot_ptr(slot)) >> 2;
        for (int w = 0; w < 16; w++) mem[pw + w] <= $urandom;
        exp_len[slot] = len;
        exp_ctl[slot] = ctl;
    endtask

    task automatic verify_slot(input int slot, input bit wb);
        int len;
        int bad;
        int mk;
        logic [9:0] e;
        logic [31:0] exp_c;
        len = exp_len[slot];
        bad = 0; mk = 0;
        if (cap_q.size() < len) begin
            chk(0, "R3 frame too short", 32'(cap_q.size()), 32'(len));
            cap_q.delete();
        end else begin
            for (int k = 0; k < len; k++) begin
                e = cap_q.pop_front();
                if (e[7:0] != exp_byte(slot, k)) bad++;
                if (e[9] != (k == 0) || e[8] != (k == len - 1)) mk++;
            end
            if (len > 0) begin
                chk(bad == 0, "R3 frame bytes (R2 layout)", 32'(bad), 0);
                chk(mk == 0, "R3 sof/eof marks", 32'(mk), 0);
            end
        end
        exp_c = wb ? (exp_ctl[slot] | 32'h8000_0000) : exp_ctl[slot];
        chk(mem[desc_word(slot) + 1] == exp_c, len == 0 ? "R9 zero-length done" : "R5 write-back",
            mem[desc_word(slot) + 1], exp_c);
    endtask

    task automatic wait_idle;
        logic [31:0] d, c;
        int t;
        t = 0;
        forever begin
            cfg_read(txr_pkg::RA_DMA, d);
            cfg_read(txr_pkg::RA_CTRL, c);
            if (d == 32'(sw_cpu) && !c[2]) break;
            t++;
            if (t > 20000) begin
                chk(0, "R6 engine did not reach CPU index", d, 32'(sw_cpu));
                break;
            end
        end
    endtask

    initial begin : main
        logic [31:0] d;
        int slots [$];
        int nb, first_slot;
        void'($urandom(32'd2718));
        for (int i = 0; i < 2048; i++) mem[i] <= '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cfg_read(txr_pkg::RA_SIZE, d); chk(d == 32'd24, "R1 ring size", d, 24);
        cfg_read(txr_pkg::RA_BASE, d); chk(d == 0, "R1 ring base", d, 0);
        cfg_read(txr_pkg::RA_CPU, d);  chk(d == 0, "R1 cpu index", d, 0);
        cfg_read(txr_pkg::RA_DMA, d);  chk(d == 0, "R1 dma index", d, 0);
        cfg_read(txr_pkg::RA_CTRL, d); chk(d == 0, "R1 control", d, 0);
        chk(!st_valid && !mem_req, "R1 outputs idle", {st_valid, mem_req}, 0);

        cfg_write(txr_pkg::RA_BASE, RING);
        cfg_write(txr_pkg::RA_CTRL, 32'd3);

        // random batches, directed lengths in the first one, wrapping the ring
        for (int b = 0; b < 9; b++) begin
            slots.delete();
            nb = (b == 0) ? 4 : $urandom_range(1, 6);
            for (int j = 0; j < nb; j++) begin
                int len;
                if (b == 0) len = (j == 0) ? 1 : (j == 1) ? 0 : (j == 2) ? 4 : 5;
                else len = ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(1, 48);
                fill_desc(sw_cpu, len);
                slots.push_back(sw_cpu);
                sw_cpu = (sw_cpu + 1) % NSLOT;
            end
            cfg_write(txr_pkg::RA_CPU, 32'(sw_cpu));
            wait_idle();
            foreach (slots[i]) verify_slot(slots[i], 1'b1);
            chk(cap_q.size() == 0, "R3 no extra bytes", 32'(cap_q.size()), 0);
            cfg_read(txr_pkg::RA_DMA, d);
            chk(d == 32'(sw_cpu), "R6 dma index follows cpu index with wrap", d, 32'(sw_cpu));
        end

        // R5: write-back disabled leaves the descriptor untouched
        cfg_write(txr_pkg::RA_CTRL, 32'd1);
        first_slot = sw_cpu;
        fill_desc(sw_cpu, 7);
        sw_cpu = (sw_cpu + 1) % NSLOT;
        cfg_write(txr_pkg::RA_CPU, 32'(sw_cpu));
        wait_idle();
        verify_slot(first_slot, 1'b0);
        cfg_write(txr_pkg::RA_CTRL, 32'd3);

        // R8: disable mid-frame, frame completes, next one not taken
        first_slot = sw_cpu;
        fill_desc(sw_cpu, 20);
        fill_desc((sw_cpu + 1) % NSLOT, 20);
        rdy_hold = 1;
        sw_cpu = (sw_cpu + 2) % NSLOT;
        cfg_write(txr_pkg::RA_CPU, 32'(sw_cpu));
        while (!st_valid) @(negedge clk);
        cfg_write(txr_pkg::RA_CTRL, 32'd2);
        cfg_read(txr_pkg::RA_CTRL, d);
        chk(d[2] == 1'b1, "R8 busy while frame in flight", d, 32'd6);
        rdy_hold = 0;
        do cfg_read(txr_pkg::RA_CTRL, d); while (d[2]);
        repeat (100) @(negedge clk);
        cfg_read(txr_pkg::RA_DMA, d);
        chk(d == 32'((first_slot + 1) % NSLOT), "R8 only in-flight descriptor finished", d,
            32'((first_slot + 1) % NSLOT));
        verify_slot(first_slot, 1'b1);
        chk(cap_q.size() == 0, "R8 no bytes from held descriptor", 32'(cap_q.size()), 0);
        cfg_write(txr_pkg::RA_CTRL, 32'd3);
        wait_idle();
        verify_slot((first_slot + 1) % NSLOT, 1'b1);

        // R7: index clear while idle
        cfg_write(txr_pkg::RA_CTRL, 32'd2);
        cfg_write(txr_pkg::RA_ICLR, 32'd1);
        cfg_read(txr_pkg::RA_DMA, d);
        chk(d == 0, "R7 index clear", d, 0);
        sw_cpu = 0;
        cfg_write(txr_pkg::RA_CPU, 32'd0);

        // R7: clear collides with the write-back that advances the index
        gnt_full = 1;
        wb_allow = 0;
        fill_desc(0, 3);
        cfg_write(txr_pkg::RA_CTRL, 32'd3);
        cfg_write(txr_pkg::RA_CPU, 32'd1);
        while (!(mem_req && mem_we)) @(negedge clk);
        cfg_write(txr_pkg::RA_CTRL, 32'd2);
        chk(mem_req && mem_we, "R10 write-back request held", {mem_req, mem_we}, 3);
        wb_allow = 1;
        cfg_we = 1'b1; cfg_addr = txr_pkg::RA_ICLR; cfg_wdata = 32'd1;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_read(txr_pkg::RA_DMA, d);
        chk(d == 0, "R7 clear wins over same-cycle advance", d, 0);
        cfg_read(txr_pkg::RA_CTRL, d);
        chk(d[2] == 1'b0, "R8 busy drops after completion", d, 32'd2);
        verify_slot(0, 1'b1);
        gnt_full = 0;

        chk(bp_err == 0 && bp_seen > 0, "R4 output held under backpressure", 32'(bp_err), 0);
        chk(rq_err == 0 && rq_seen > 0, "R10 request held until grant", 32'(rq_err), 0);

        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R6 run did not finish actual=%0d expected=%0d", 150000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule